// File: doc/BRIEF.md
# Cascadable Parallel-Load Serializer with Clock Enable

The block turns a word of already-filtered field bits into a serial bit stream for a host that reads it as an SPI-style target. A host drives four slow pins: an active-low load strobe, a serial clock, an active-low clock enable and a serial data input. The block samples these pins with a fast system clock, finds the serial-clock edges itself, and runs a shift register from the detected edges. While the load strobe is low, the field word is captured continuously. While it is high and the enable is low, each serial-clock cycle moves one bit out.

The register has three kinds of stage. There are `WIDTH-1` loadable chain stages that advance on serial-clock rising edges. A transfer stage after them also advances on rising edges but is never loaded. The output stage is loadable and takes the transfer stage's value on serial-clock falling edges. Bit 0 is loaded straight into the output stage, so it is visible as soon as the load ends. The serial input feeds the first chain stage, so several blocks can be chained output-to-input and read with `WIDTH` clocks per block.

Because the transfer stage is not loaded, the enable must fall while the serial clock is low. If a falling edge comes first, the transfer stage's leftover value appears as one extra bit.

Top module: `piso_serializer`

## Requirements
- R1: While `load_n` is low, `sout` equals `par_in[0]` and follows changes of `par_in`, whatever `sclk`, `sce_n` and `sin` do.
- R2: While `load_n` is high, changes of `par_in` have no effect on `sout` or on the bits later shifted out.
- R3: With `load_n` high and `sce_n` high, serial-clock edges of either polarity shift nothing, and `sout` keeps its value.
- R4: With `load_n` high and `sce_n` low, a rising `sclk` edge moves every chain stage one place toward the output. `sin` enters the first stage, and the transfer stage takes the last chain stage.
- R5: With `load_n` high and `sce_n` low, a falling `sclk` edge copies the transfer stage into the output stage, and `sout` always shows the output stage.
- R6: After a load and `sce_n` falling while `sclk` is low, `sout` shows `par_in[0]` first. Bit k follows the k-th falling edge for k = 1 to `WIDTH-1`. After `WIDTH` full clock cycles, `sout` shows the level that was on `sin`.
- R7: With two blocks chained (the downstream `sout` into the upstream `sin`), `2*WIDTH` correctly phased clocks present the upstream word bit 0 first, then the downstream word bit 0 first.
- R8: If `sce_n` falls while `sclk` is high, the first falling edge shows the transfer stage's leftover value (the last bit shifted into it) instead of bit 1. Bits 1 onward then follow one falling edge late.
- R9: After reset every stage holds 1, so `sout` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_in | input | WIDTH | Filtered field bits; bit 0 leaves first |
| load_n | input | 1 | Active-low parallel load strobe |
| sclk | input | 1 | Serial clock from the host |
| sce_n | input | 1 | Active-low serial clock enable |
| sin | input | 1 | Serial data input for cascading |
| sout | output | 1 | Serial data output |

## Verification
The bench builds two instances with the default `WIDTH` of 8 and two synchronizer stages, chained output-to-input. A sixteen-clock read therefore covers both the in-chain handoff and the tail level from `sin`. The eight-bit width keeps the full bit order, the late-bit shift of the misphased enable, and the leftover transfer-stage value within a short run. The serial clock's half-period of eight system clocks leaves room for the three-cycle pin-to-register latency on both sides of each edge.

// File: rtl/piso_pkg.sv
package piso_pkg;

    localparam int unsigned DEF_WIDTH = 8;
    localparam int unsigned DEF_SYNC  = 2;

    typedef enum logic [1:0] {
        MODE_LOAD    = 2'd0,
        MODE_INHIBIT = 2'd1,
        MODE_SHIFT   = 2'd2
    } piso_mode_e;

    typedef struct packed {
        logic load_n;
        logic sclk;
        logic ce_n;
        logic sdi;
    } pin_sample_t;

    localparam pin_sample_t PIN_IDLE = '{load_n: 1'b1, sclk: 1'b0, ce_n: 1'b1, sdi: 1'b1};

endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
    parameter int unsigned         W      = 4,
    parameter int unsigned         STAGES = 2,
    parameter logic [W-1:0]        RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST}};
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb prev_d = lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/piso_shift_core.sv
module piso_shift_core
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             load_n_s,
    input  logic             ce_n_s,
    input  logic             sdi_s,
    input  logic             rise,
    input  logic             fall,
    output logic             sout
);
    localparam int unsigned XFER = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] chain;
        logic             out;
    } core_state_t;

    core_state_t st_d, st_q;
    piso_mode_e  mode;

    always_comb begin
        if (!load_n_s)   mode = MODE_LOAD;
        else if (ce_n_s) mode = MODE_INHIBIT;
        else             mode = MODE_SHIFT;

        st_d = st_q;
        case (mode)
            MODE_LOAD: begin
                st_d.out = par_in[0];
                for (int j = 0; j < int'(WIDTH) - 1; j++) begin
                    st_d.chain[WIDTH-2-j] = par_in[j+1];
                end
            end
            MODE_SHIFT: begin
                if (rise) st_d.chain = {st_q.chain[WIDTH-2:0], sdi_s};
                if (fall) st_d.out   = st_q.chain[XFER];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    assign sout = st_q.out;

    p_load_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_s |=> (st_q.out == $past(par_in[0])));

    p_out_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !fall) |=> $stable(st_q.out));

    p_shift_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && ce_n_s) |=> $stable(st_q));

    p_rise_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !ce_n_s && rise) |=> (st_q.chain[XFER] == $past(st_q.chain[XFER-1])));

    p_fall_transfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !ce_n_s && fall) |=> (st_q.out == $past(st_q.chain[XFER])));

    p_chain_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !rise) |=> $stable(st_q.chain));
endmodule

// File: rtl/piso_serializer.sv
module piso_serializer
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH       = DEF_WIDTH,
    parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             load_n,
    input  logic             sclk,
    input  logic             sce_n,
    input  logic             sin,
    output logic             sout
);
    localparam int unsigned PIN_W = $bits(pin_sample_t);

    pin_sample_t       raw, smp;
    logic [PIN_W-1:0]  smp_vec;
    logic              sclk_rise, sclk_fall;

    always_comb begin
        raw.load_n = load_n;
        raw.sclk   = sclk;
        raw.ce_n   = sce_n;
        raw.sdi    = sin;
    end

    piso_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST    (PIN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw),
        .dout  (smp_vec)
    );

    assign smp = pin_sample_t'(smp_vec);

    piso_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (smp.sclk),
        .rise  (sclk_rise),
        .fall  (sclk_fall)
    );

    piso_shift_core #(
        .WIDTH (WIDTH)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .par_in   (par_in),
        .load_n_s (smp.load_n),
        .ce_n_s   (smp.ce_n),
        .sdi_s    (smp.sdi),
        .rise     (sclk_rise),
        .fall     (sclk_fall),
        .sout     (sout)
    );

    p_edge_needs_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise || sclk_fall) |-> (smp.sclk != $past(smp.sclk)));
endmodule

// File: tb/piso_serializer_test.sv
module piso_serializer_test;
    localparam int W  = 8;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] pa = '0, pb = '0;
    logic load_n = 1'b1, sclk = 1'b0, sce_n = 1'b1, sin_tb = 1'b1;
    logic sout_a, sout_b;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    piso_serializer #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .par_in(pa), .load_n(load_n),
        .sclk(sclk), .sce_n(sce_n), .sin(sout_b), .sout(sout_a)
    );

    piso_serializer #(.WIDTH(W)) uut_b (
        .clk(clk), .rst_n(rst_n), .par_in(pb), .load_n(load_n),
        .sclk(sclk), .sce_n(sce_n), .sin(sin_tb), .sout(sout_b)
    );

    localparam logic [15:0] PAIRS [4] = '{16'hA53C, 16'h0FF0, 16'h8101, 16'h7E96};

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse();
        sclk = 1'b1; cyc(HP);
        sclk = 1'b0; cyc(HP);
    endtask

    task automatic do_load(input logic [W-1:0] a, input logic [W-1:0] b);
        pa = a; pb = b;
        load_n = 1'b0; cyc(HP);
        load_n = 1'b1; cyc(HP);
    endtask

    task automatic read_chain(input logic [W-1:0] a, input logic [W-1:0] b);
        sce_n = 1'b0; cyc(HP);
        for (int i = 0; i < 2*W; i++) begin
            if (i < W) check("R6 upstream bit order", sout_a, a[i]);
            else       check("R7 chained downstream bit", sout_a, b[i-W]);
            pulse();
        end
        check("R6 tail shows serial input", sout_a, sin_tb);
        sce_n = 1'b1; cyc(HP);
    endtask

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        check("R9 reset output high", sout_a, 1'b1);
        check("R9 reset downstream high", sout_b, 1'b1);

        // R4 R5 R6 R7: table of word pairs, each read with sixteen clocks
        for (int t = 0; t < 4; t++) begin
            do_load(PAIRS[t][15:8], PAIRS[t][7:0]);
            read_chain(PAIRS[t][15:8], PAIRS[t][7:0]);
        end

        // R1: load held low ignores clock, enable and serial input
        pa = 8'h01; load_n = 1'b0; sce_n = 1'b0; sin_tb = 1'b0;
        cyc(HP);
        pulse(); pulse();
        check("R1 load follows bit0", sout_a, 1'b1);
        pa = 8'hFE; cyc(HP);
        check("R1 load tracks change", sout_a, 1'b0);
        load_n = 1'b1; sce_n = 1'b1; sin_tb = 1'b1; cyc(HP);

        // R2: parallel input blocked after load
        do_load(8'hC6, 8'h11);
        pa = 8'h39; cyc(HP);
        check("R2 par ignored when load high", sout_a, 1'b0);
        read_chain(8'hC6, 8'h11);

        // R3: enable high inhibits shifting
        do_load(8'h6A, 8'h55);
        pulse(); pulse(); pulse();
        check("R3 inhibit keeps bit0", sout_a, 1'b0);
        read_chain(8'h6A, 8'h55);

        // R8: enable falls while clock high; stale transfer value is 1
        do_load(8'hA4, 8'h00);
        sclk = 1'b1; cyc(HP);
        sce_n = 1'b0; cyc(HP);
        check("R8 first bit0", sout_a, 1'b0);
        sclk = 1'b0; cyc(HP);
        check("R8 stale extra bit", sout_a, 1'b1);
        for (int k = 2; k < W; k++) begin
            pulse();
            check("R8 delayed bit", sout_a, pa[k-1]);
        end
        sce_n = 1'b1; cyc(HP);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule